// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that software reaches through a small register bus with an address, write data, a write strobe and combinational read data. It holds a 32-bit up-counter that starts from a programmed load value and advances on ticks from a power-of-two prescaler. When the counter passes its all-ones value, the block raises a one-cycle reset request and reloads from the load register. Software keeps the system alive by writing a new pattern to the trigger register, which restarts the count from the load value.

Software cannot start or stop the counter with a single write. It must write a two-word key sequence to the key register, and any wrong word cancels the sequence. Every writable register has a write-pending flag, which models a posted write. The flag stays set for a fixed number of cycles after an accepted write, and a further write to that register while its flag is set is dropped. The control and load registers are also frozen while the counter runs, so software stops the timer before it reprograms it.

Top module: `wdog_keyed`

## Requirements
- R1: Writing 0x0000BBBB to the key register and then 0x00004444 as the next key write starts the counter from the load value. The prescaler phase restarts on the second write.
- R2: Writing 0x0000AAAA to the key register and then 0x00005555 as the next key write stops the counter. No reset request follows the stop.
- R3: A key write that is not the expected next word returns the key sequencer to idle and leaves the running state as it was. For example, 0xBBBB, 0x1234, 0x4444 does not start the counter, and 0xAAAA, 0x1111, 0x5555 does not stop it.
- R4: Bit 0 of the status register is the control pending flag, bit 2 the load flag, bit 3 the trigger flag and bit 4 the key flag. All other bits read 0. An accepted write sets its flag, and the flag reads 1 for exactly 4 cycles.
- R5: A write to a register whose pending flag is set is ignored.
- R6: Writes to the control and load registers are ignored while the counter runs. The same writes take effect after a stop.
- R7: A trigger write reloads the counter from the load register only when its data differs from the previous trigger data written. The value after reset is 0.
- R8: When the counter advances past 0xFFFFFFFF, reset_req is 1 for one cycle and the counter reloads. The pulse comes (2^32 - load) ticks after a start, after a reload, or after the previous pulse.
- R9: Control bit 5 enables the prescaler and control bits 4:2 hold its exponent p. With the prescaler enabled, a tick occurs every 2^p cycles. With the prescaler disabled, a tick occurs every cycle.
- R10: After reset the counter is stopped, the control, load, trigger and status registers read 0, the key sequencer is idle and reset_req is 0.
- R11: The word addresses are control 0, load 1, trigger 2, key 3 and status 4. Reads of the key register and of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| reset_req | output | 1 | One-cycle reset request on counter overflow |

## Verification
The bench measures the cycle distance from the start write to each reset_req pulse across several load values and prescaler settings. A wrong tick divide or an off-by-one reload would show up as a shifted pulse. It feeds broken key sequences and expects the running state to hold, because a sequencer that remembers a half-matched key would start or stop the counter. It writes back to back into a pending register and into frozen registers while the counter runs, then reads them back to catch a design that lets those writes through. It repeats trigger values to catch a design that reloads on every trigger write rather than only on a changed pattern.

// File: rtl/wdog_pkg.sv
// Package: shared register addresses, key words and sequencer states for
// the keyed watchdog. Assumes word addressing on a 3-bit address bus.
package wdog_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_TRIG = 3'd2;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    // indices into the per-register pending vector
    localparam int PI_CTRL = 0;
    localparam int PI_LOAD = 1;
    localparam int PI_TRIG = 2;
    localparam int PI_KEY  = 3;
    localparam int NUM_PEND = 4;

    localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
    localparam logic [15:0] KEY_RUN_B  = 16'h4444;
    localparam logic [15:0] KEY_HALT_A = 16'hAAAA;
    localparam logic [15:0] KEY_HALT_B = 16'h5555;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARM_RUN,
        KS_ARM_HALT
    } key_state_t;
endpackage

// File: rtl/wdog_pend_flag.sv
// Module: wdog_pend_flag
// Models one posted-write pending flag. A set pulse loads a down-counter with
// PEND_CYCLES; busy stays high while the counter is non-zero. Assumes the
// caller only pulses set when busy is low.
module wdog_pend_flag #(
    parameter int PEND_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic busy
);
    localparam int CW = $clog2(PEND_CYCLES + 1);

    logic [CW-1:0] remain;

    // load on an accepted write, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (set) begin
            remain <= CW'(PEND_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/wdog_key_seq.sv
// Module: wdog_key_seq
// Two-word key sequencer that owns the running state. A first key word arms
// start or stop; the matching second word completes it. Any other word
// returns to idle without touching the running state. Assumes key_wr is
// already qualified by the pending flag.
module wdog_key_seq
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              running,
    output logic              start_p
);
    localparam logic [DATA_W-1:0] W_RUN_A  = DATA_W'(KEY_RUN_A);
    localparam logic [DATA_W-1:0] W_RUN_B  = DATA_W'(KEY_RUN_B);
    localparam logic [DATA_W-1:0] W_HALT_A = DATA_W'(KEY_HALT_A);
    localparam logic [DATA_W-1:0] W_HALT_B = DATA_W'(KEY_HALT_B);

    key_state_t state, state_nx;
    logic       stop_p;

    // next-state and completion pulses of the key handshake
    always_comb begin
        state_nx = state;
        start_p  = 1'b0;
        stop_p   = 1'b0;
        if (key_wr) begin
            state_nx = KS_IDLE;
            unique case (state)
                KS_IDLE: begin
                    if (key_data == W_RUN_A)       state_nx = KS_ARM_RUN;
                    else if (key_data == W_HALT_A) state_nx = KS_ARM_HALT;
                end
                KS_ARM_RUN:  start_p = (key_data == W_RUN_B);
                KS_ARM_HALT: stop_p  = (key_data == W_HALT_B);
                default:     state_nx = KS_IDLE;
            endcase
        end
    end

    // state and running flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= KS_IDLE;
            running <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_p)     running <= 1'b1;
            else if (stop_p) running <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_prescaler.sv
// Module: wdog_prescaler
// Produces the count tick. Disabled: one tick per cycle while running.
// Enabled: one tick every 2^ptv cycles, phase restarted by restart.
// Assumes ptv is only changed while stopped.
module wdog_prescaler #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             pen,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick
);
    localparam int PRE_W = (1 << PTV_W) - 1;

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] limit;

    // terminal phase value for the selected exponent
    always_comb begin
        limit = ({{(PRE_W-1){1'b0}}, 1'b1} << ptv) - 1'b1;
        tick  = run && (!pen || (phase == limit));
    end

    // divide counter, cleared on restart, when stopped or on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || !run || !pen || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Up-counter with overflow detection. reload copies load_val into the count;
// a tick at all-ones pulses overflow for one cycle and reloads. Assumes tick
// is low whenever the timer is stopped.
module wdog_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reload,
    input  logic [DATA_W-1:0] load_val,
    output logic              overflow
);
    logic [DATA_W-1:0] count;

    // count, reload and overflow pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= 1'b0;
            if (reload) begin
                count <= load_val;
            end else if (tick) begin
                if (count == {DATA_W{1'b1}}) begin
                    count    <= load_val;
                    overflow <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_keyed.sv
// Module: wdog_keyed (top)
// Register-mapped watchdog: control, load, trigger, key and pending status.
// Holds the bus decode, the register storage and the read mux, and places one
// pending flag per writable register, the key sequencer, the prescaler and the
// counter. Assumes at most one bus write per cycle.
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PEND_CYCLES = 4,
    parameter int PTV_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);
    localparam int PTV_LSB = 2;
    localparam int PEN_BIT = PTV_LSB + PTV_W;

    logic [NUM_PEND-1:0] wr_sel;
    logic [NUM_PEND-1:0] accept;
    logic [NUM_PEND-1:0] busy;
    logic                ctrl_pen;
    logic [PTV_W-1:0]    ctrl_ptv;
    logic [DATA_W-1:0]   load_q;
    logic [DATA_W-1:0]   trig_q;
    logic                running;
    logic                start_p;
    logic                trig_reload;
    logic                tick;

    // write address decode per writable register
    always_comb begin
        wr_sel          = '0;
        wr_sel[PI_CTRL] = bus_we && (bus_addr == A_CTRL);
        wr_sel[PI_LOAD] = bus_we && (bus_addr == A_LOAD);
        wr_sel[PI_TRIG] = bus_we && (bus_addr == A_TRIG);
        wr_sel[PI_KEY]  = bus_we && (bus_addr == A_KEY);
    end

    // one posted-write flag per register; a write while busy is dropped
    for (genvar gi = 0; gi < NUM_PEND; gi++) begin : g_pend
        assign accept[gi] = wr_sel[gi] && !busy[gi];
        wdog_pend_flag #(.PEND_CYCLES(PEND_CYCLES)) u_pend (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (accept[gi]),
            .busy (busy[gi])
        );
    end

    assign trig_reload = accept[PI_TRIG] && (bus_wdata != trig_q);

    // configuration registers, frozen while the counter runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_pen <= 1'b0;
            ctrl_ptv <= '0;
            load_q   <= '0;
        end else if (!running) begin
            if (accept[PI_CTRL]) begin
                ctrl_pen <= bus_wdata[PEN_BIT];
                ctrl_ptv <= bus_wdata[PEN_BIT-1:PTV_LSB];
            end
            if (accept[PI_LOAD]) begin
                load_q <= bus_wdata;
            end
        end
    end

    // last trigger pattern written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else if (accept[PI_TRIG]) begin
            trig_q <= bus_wdata;
        end
    end

    wdog_key_seq #(.DATA_W(DATA_W)) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (accept[PI_KEY]),
        .key_data(bus_wdata),
        .running (running),
        .start_p (start_p)
    );

    wdog_prescaler #(.PTV_W(PTV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .restart(start_p),
        .pen    (ctrl_pen),
        .ptv    (ctrl_ptv),
        .tick   (tick)
    );

    wdog_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .reload  (start_p || trig_reload),
        .load_val(load_q),
        .overflow(reset_req)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[PEN_BIT]               = ctrl_pen;
                bus_rdata[PEN_BIT-1:PTV_LSB]     = ctrl_ptv;
            end
            A_LOAD: bus_rdata = load_q;
            A_TRIG: bus_rdata = trig_q;
            A_STAT: begin
                bus_rdata[0] = busy[PI_CTRL];
                bus_rdata[2] = busy[PI_LOAD];
                bus_rdata[3] = busy[PI_TRIG];
                bus_rdata[4] = busy[PI_KEY];
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_keyed_chk.sv
// Module: wdog_keyed_chk
// Property checker bound into wdog_keyed. Watches the bus, the running
// state, the pending flags and the configuration registers.
module wdog_keyed_chk
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PTV_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              running,
    input logic              reset_req,
    input logic [3:0]        busy,
    input logic              ctrl_pen,
    input logic [PTV_W-1:0]  ctrl_ptv,
    input logic [DATA_W-1:0] load_q
);
    // R8: a reset request only follows a cycle in which the counter ran
    assert_req_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(running));

    // R1 / R2: running changes only after a key-register write
    assert_run_by_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(running) |-> $past(bus_we && bus_addr == A_KEY));

    // R4: an accepted load write raises the load pending flag
    assert_load_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_LOAD && !busy[PI_LOAD]) |=> busy[PI_LOAD]);

    // R5: a load write while pending leaves the load register unchanged
    assert_pending_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_LOAD && busy[PI_LOAD]) |=> $stable(load_q));

    // R6: control writes while running leave the control fields unchanged
    assert_ctrl_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && bus_we && bus_addr == A_CTRL) |=> $stable({ctrl_pen, ctrl_ptv}));
endmodule

bind wdog_keyed wdog_keyed_chk #(.DATA_W(DATA_W), .PTV_W(PTV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .running  (running),
    .reset_req(reset_req),
    .busy     (busy),
    .ctrl_pen (ctrl_pen),
    .ctrl_ptv (ctrl_ptv),
    .load_q   (load_q)
);

// File: tb/wdog_keyed_tb.sv
// Bench for wdog_keyed: table of timing vectors, then directed tests.
module wdog_keyed_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [2:0] AC = 3'd0, AL = 3'd1, AT = 3'd2, AK = 3'd3, AS = 3'd4;

    typedef struct packed {
        logic [31:0] ld;
        logic        pen;
        logic [2:0]  ptv;
        logic [31:0] expc;
    } vec_t;

    // expected cycles = (2^32 - load) * (pen ? 2^ptv : 1)
    localparam vec_t VECS [6] = '{
        '{32'hFFFF_FFFE, 1'b0, 3'd0, 32'd2},
        '{32'hFFFF_FFF0, 1'b0, 3'd0, 32'd16},
        '{32'hFFFF_FFFA, 1'b1, 3'd2, 32'd24},
        '{32'hFFFF_FFFD, 1'b1, 3'd7, 32'd384},
        '{32'hFFFF_FFFC, 1'b0, 3'd3, 32'd4},
        '{32'hFFFF_FFF8, 1'b1, 3'd0, 32'd8}
    };

    wdog_keyed u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_rdata(bus_rdata),
        .reset_req(reset_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one write strobe, returns at the negedge after the write edge
    task automatic wr_now(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // write and let the pending flag clear
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_now(a, d);
        repeat (5) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // cycles until reset_req is seen, 0 if not within lim
    task automatic measure(input int lim, output int n);
        int k = 0;
        n = 0;
        while (k < lim) begin
            @(negedge clk);
            k++;
            if (reset_req) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic start_seq();
        wr(AK, 32'h0000_BBBB);
        wr_now(AK, 32'h0000_4444);
    endtask

    task automatic stop_seq();
        wr(AK, 32'h0000_AAAA);
        wr(AK, 32'h0000_5555);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int n;
        int m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R11: reset state of every readable register
        rd(AC, v); chk(v == 0, "R10 ctrl", v, 0);
        rd(AL, v); chk(v == 0, "R10 load", v, 0);
        rd(AT, v); chk(v == 0, "R10 trigger", v, 0);
        rd(AS, v); chk(v == 0, "R10 status", v, 0);
        rd(AK, v); chk(v == 0, "R11 key reads 0", v, 0);
        measure(30, n); chk(n == 0, "R10 stopped, no reset_req", n, 0);

        // R4: each flag at its own bit, high for exactly 4 cycles
        wr_now(AL, 32'h1234_5678);
        rd(AS, v); chk(v == 32'h4, "R4 load flag bit 2", v, 4);
        repeat (3) @(negedge clk);
        rd(AS, v); chk(v == 32'h4, "R4 load flag in cycle 4", v, 4);
        @(negedge clk);
        rd(AS, v); chk(v == 0, "R4 load flag cleared", v, 0);
        wr_now(AC, 32'h0);
        rd(AS, v); chk(v == 32'h1, "R4 ctrl flag bit 0", v, 1);
        repeat (5) @(negedge clk);
        wr_now(AT, 32'h0);
        rd(AS, v); chk(v == 32'h8, "R4 trigger flag bit 3", v, 8);
        repeat (5) @(negedge clk);
        wr_now(AK, 32'h0);
        rd(AS, v); chk(v == 32'h10, "R4 key flag bit 4", v, 16);
        repeat (5) @(negedge clk);

        // R5: back-to-back write to a pending register is dropped
        wr_now(AL, 32'h0000_00AA);
        wr_now(AL, 32'h0000_00BB);
        repeat (5) @(negedge clk);
        rd(AL, v); chk(v == 32'hAA, "R5 second load write dropped", v, 32'hAA);

        // R3: broken start sequences do not start the counter
        wr(AC, 32'h0);
        wr(AL, 32'hFFFF_FFF8);
        wr(AK, 32'h0000_BBBB);
        wr(AK, 32'h0000_1234);
        wr(AK, 32'h0000_4444);
        measure(40, n); chk(n == 0, "R3 bad start word ignored", n, 0);
        wr(AK, 32'h0000_AAAA);
        wr(AK, 32'h0000_4444);
        measure(40, n); chk(n == 0, "R3 cross-key ignored", n, 0);

        // R1: proper start, first pulse after 8 ticks
        start_seq();
        measure(100, n); chk(n == 8, "R1 start then overflow", n, 8);

        // R6: ctrl and load writes ignored while running
        wr(AC, 32'h0000_003C);
        rd(AC, v); chk(v == 0, "R6 ctrl frozen", v, 0);
        wr(AL, 32'h0000_0005);
        rd(AL, v); chk(v == 32'hFFFF_FFF8, "R6 load frozen", v, 32'hFFFF_FFF8);

        // R3: broken stop sequence leaves it running
        wr(AK, 32'h0000_AAAA);
        wr(AK, 32'h0000_1111);
        wr(AK, 32'h0000_5555);
        measure(20, n); chk(n != 0, "R3 bad stop word ignored", n, 1);

        // R2: proper stop silences reset_req
        stop_seq();
        measure(60, n); chk(n == 0, "R2 stopped", n, 0);
        wr(AC, 32'h0000_0028);
        rd(AC, v); chk(v == 32'h28, "R6 ctrl writable after stop", v, 32'h28);

        // R8 / R9: table of load values and prescaler settings
        for (int i = 0; i < 6; i++) begin
            stop_seq();
            wr(AC, {26'd0, VECS[i].pen, VECS[i].ptv, 2'b00});
            wr(AL, VECS[i].ld);
            start_seq();
            measure(1000, n);
            chk(n == int'(VECS[i].expc), "R9 first period", n, VECS[i].expc);
            @(negedge clk);
            chk(reset_req == 1'b0, "R8 pulse is one cycle", reset_req, 0);
            measure(1000, m);
            chk(m + 1 == int'(VECS[i].expc), "R8 reload period", m + 1, VECS[i].expc);
        end
        stop_seq();

        // R7: trigger reloads only on a changed pattern (last written is 0)
        wr(AC, 32'h0);
        wr(AL, 32'hFFFF_FFF0);
        start_seq();
        wr_now(AT, 32'h0);
        measure(100, n); chk(n + 1 == 16, "R7 same trigger no reload", n + 1, 16);
        stop_seq();
        start_seq();
        wr_now(AT, 32'h1);
        measure(100, n); chk(n + 1 == 17, "R7 new trigger reloads", n + 1, 17);
        stop_seq();
        start_seq();
        wr_now(AT, 32'h1);
        measure(100, n); chk(n + 1 == 16, "R7 repeat trigger no reload", n + 1, 16);
        stop_seq();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule